// File: doc/BRIEF.md
# Prescaled 8-bit PWM generator

This block drives one pulse-width-modulated output, of the kind that sets the brightness of a display backlight. Each period is 256 prescaled ticks long. A free-running counter is compared against an 8-bit duty value, so the output is active for duty/256 of the period. The tick that advances the counter comes from one of two clock-enable inputs, a slow one or a system one. A power-of-two divider of 1 to 64 then slows it further.

Software reaches the block through a small register file with a write strobe, an address, write data and combinational read data. A configuration word holds the duty, the polarity and the divider exponent. A source word selects the tick. Two write-one strobe registers request start and stop. A status word reports whether the channel is really running. Start and stop take effect on a prescaled tick boundary, so software polls the status after each request.

Top module: `pwm8_prescaled`

## Requirements
- R1: After reset the status bit reads 0, the configuration word reads 0 (duty 0, inverted polarity, exponent 0), the source word reads 0 (slow tick), and the output is high.
- R2: The configuration word (address 0) keeps the duty in bits 15:8, the polarity in bit 4 and the divider exponent in bits 2:0; it reads back as written, and all other bits read 0.
- R3: While running with normal polarity, one period lasts 256 prescaled ticks and the output is high for exactly duty ticks of it; duty 0 keeps it low for the whole period, and duty 255 gives 255 high ticks.
- R4: An exponent n from 0 to 6 divides the selected tick by 2^n; the value 7 behaves exactly like 6.
- R5: Polarity bit set gives an active-high output; cleared gives the complement. A change of this bit shows on the output at once, whether running or stopped.
- R6: Bit 0 of the source word (address 1) selects the system tick when 1 and the slow tick when 0.
- R7: Writing 1 to bit 0 of the start register (address 2) requests running; the status bit rises only on a later prescaled tick, never in the cycle of the write. Writing 0 there changes nothing.
- R8: Writing 1 to bit 0 of the stop register (address 3) stops the channel on the next prescaled tick; while stopped the counter stays at 0 and the output sits at the inactive level for the current polarity. Writing 0 there changes nothing.
- R9: A new duty or exponent written during a running period takes effect only when the counter wraps to start the next period.
- R10: Bit 0 of the status word (address 4) reads 1 exactly while the channel is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | Slow clock-enable tick |
| sys_tick_i | input | 1 | System clock-enable tick |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| pwm_o | output | 1 | PWM output |

## Verification
The duty comparison is tested with duty values 0, 64, 200 and 255, counting high cycles over a full period. This separates an off-by-one in the compare from a wrong period length. Periods and high times are measured at exponents 0, 2 and 7, and with the slow tick at one pulse in four cycles. These show whether the divider applies 2^n, clamps 7 to 6, and follows the source bit. A duty change in the low part of a period shows whether shadowing waits for the wrap. Polls of the status after start and stop requests, and after writes of 0, show the tick-aligned handshake. The same polls show that writes of 0 have no effect.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
   localparam int CNT_W    = 8;
   localparam int EXP_W    = 3;
   localparam int DUTY_LSB = 8;
   localparam int POL_BIT  = 4;
   localparam int EXP_LSB  = 0;

   localparam int ADR_CFG  = 0;
   localparam int ADR_SRC  = 1;
   localparam int ADR_ON   = 2;
   localparam int ADR_OFF  = 3;
   localparam int ADR_STAT = 4;

   typedef struct packed {
      logic [CNT_W-1:0] duty;
      logic             pol;
      logic [EXP_W-1:0] expo;
   } cfg_t;
endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs
   import pwm8_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              run_i,
   output cfg_t              cfg_o,
   output logic              sys_sel_o,
   output logic              want_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADR_CFG);
   localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(ADR_SRC);
   localparam logic [ADDR_W-1:0] A_ON   = ADDR_W'(ADR_ON);
   localparam logic [ADDR_W-1:0] A_OFF  = ADDR_W'(ADR_OFF);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);

   cfg_t cfg_q;
   logic sel_q, want_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q  <= '0;
         sel_q  <= 1'b0;
         want_q <= 1'b0;
      end else if (wr_i) begin
         case (addr_i)
            A_CFG: begin
               cfg_q.duty <= wdata_i[DUTY_LSB +: CNT_W];
               cfg_q.pol  <= wdata_i[POL_BIT];
               cfg_q.expo <= wdata_i[EXP_LSB +: EXP_W];
            end
            A_SRC: sel_q <= wdata_i[0];
            A_ON:  if (wdata_i[0]) want_q <= 1'b1;
            A_OFF: if (wdata_i[0]) want_q <= 1'b0;
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_CFG: begin
            rdata_o[DUTY_LSB +: CNT_W] = cfg_q.duty;
            rdata_o[POL_BIT]           = cfg_q.pol;
            rdata_o[EXP_LSB +: EXP_W]  = cfg_q.expo;
         end
         A_SRC:  rdata_o[0] = sel_q;
         A_STAT: rdata_o[0] = run_i;
         default: ;
      endcase
   end

   logic unused_wbits;
   generate
      if (DATA_W > DUTY_LSB + CNT_W) begin : g_wide
         assign unused_wbits = ^{wdata_i[DATA_W-1:DUTY_LSB+CNT_W],
                                 wdata_i[7:5], wdata_i[3]};
      end else begin : g_exact
         assign unused_wbits = ^{wdata_i[7:5], wdata_i[3]};
      end
   endgenerate

   assign cfg_o     = cfg_q;
   assign sys_sel_o = sel_q;
   assign want_o    = want_q;

   // R7: a start write with bit 0 set raises the request
   p_on_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == A_ON && wdata_i[0]) |=> want_q);
   // R7: a zero written to the start register leaves the request alone
   p_on_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == A_ON && !wdata_i[0]) |=> $stable(want_q));
   // R8: a stop write with bit 0 set drops the request
   p_off_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == A_OFF && wdata_i[0]) |=> !want_q);
endmodule

// File: rtl/pwm8_divider.sv
module pwm8_divider
   import pwm8_pkg::*;
#(
   parameter int EXP_MAX = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             slow_tick_i,
   input  logic             sys_tick_i,
   input  logic             sys_sel_i,
   input  logic [EXP_W-1:0] expo_i,
   output logic             ptick_o
);
   localparam int DIV_W = EXP_MAX;

   logic             src_tick;
   logic [DIV_W:0]   lim_full;
   logic [DIV_W-1:0] div_q;

   assign src_tick = sys_sel_i ? sys_tick_i : slow_tick_i;
   assign lim_full = ((DIV_W+1)'(1) << expo_i) - (DIV_W+1)'(1);
   // >= so that a smaller exponent loaded while idle never stalls the count
   assign ptick_o  = src_tick && (div_q >= lim_full[DIV_W-1:0]);

   logic unused_lim;
   assign unused_lim = lim_full[DIV_W];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       div_q <= '0;
      else if (src_tick) div_q <= ptick_o ? '0 : div_q + 1'b1;
   end

   // R4: the divider only ever sees a clamped exponent
   p_expo_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expo_i <= EXP_W'(EXP_MAX));
   // R6: the divider stands still when the selected source is quiet
   p_hold_no_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sys_sel_i ? sys_tick_i : slow_tick_i) |=> $stable(div_q));
endmodule

// File: rtl/pwm8_core.sv
module pwm8_core
   import pwm8_pkg::*;
#(
   parameter int EXP_MAX = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ptick_i,
   input  logic             want_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic [EXP_W-1:0] expo_i,
   output logic [EXP_W-1:0] expo_act_o,
   output logic             run_o,
   output logic             active_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;
   localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(EXP_MAX);

   logic             run_q;
   logic [CNT_W-1:0] cnt_q, duty_sh;
   logic [EXP_W-1:0] expo_sh, expo_cl;
   logic             wrap;

   assign expo_cl = (expo_i > EXP_LIM) ? EXP_LIM : expo_i;
   assign wrap    = ptick_i && (cnt_q == CNT_TOP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= 1'b0;
         cnt_q   <= '0;
         duty_sh <= '0;
         expo_sh <= '0;
      end else if (!run_q) begin
         cnt_q   <= '0;
         duty_sh <= duty_i;
         expo_sh <= expo_cl;
         if (ptick_i && want_i) run_q <= 1'b1;
      end else if (ptick_i) begin
         if (!want_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (wrap) begin
               duty_sh <= duty_i;
               expo_sh <= expo_cl;
            end
         end
      end
   end

   assign expo_act_o = expo_sh;
   assign run_o      = run_q;
   assign active_o   = run_q && (cnt_q < duty_sh);

   // R7, R8: the running state only changes on a prescaled tick
   p_run_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(run_q) || $fell(run_q)) |-> $past(ptick_i));
   // R8: a stopped channel keeps its counter at zero
   p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q |-> (cnt_q == '0));
   // R3: each tick of a running channel advances the count by one
   p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && want_i && ptick_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
   // R9: shadowed duty and exponent hold between wraps
   p_shadow_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && !wrap) |=> ($stable(duty_sh) && $stable(expo_sh)));
endmodule

// File: rtl/pwm8_prescaled.sv
module pwm8_prescaled
   import pwm8_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 3,
   parameter int EXP_MAX = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              slow_tick_i,
   input  logic              sys_tick_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              pwm_o
);
   generate
      if (DATA_W < DUTY_LSB + CNT_W) begin : g_bad_data
         $error("DATA_W too narrow for the duty field");
      end
      if (EXP_MAX < 1 || EXP_MAX > (1 << EXP_W) - 2) begin : g_bad_exp
         $error("EXP_MAX must lie in 1 .. 2^EXP_W-2");
      end
      if ((1 << ADDR_W) <= ADR_STAT) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   cfg_t             cfg;
   logic             sys_sel, want, run, active, ptick;
   logic [EXP_W-1:0] expo_act;

   pwm8_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (reg_wr_i),
      .addr_i    (reg_addr_i),
      .wdata_i   (reg_wdata_i),
      .run_i     (run),
      .cfg_o     (cfg),
      .sys_sel_o (sys_sel),
      .want_o    (want),
      .rdata_o   (reg_rdata_o)
   );

   pwm8_divider #(.EXP_MAX(EXP_MAX)) u_div (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .slow_tick_i (slow_tick_i),
      .sys_tick_i  (sys_tick_i),
      .sys_sel_i   (sys_sel),
      .expo_i      (expo_act),
      .ptick_o     (ptick)
   );

   pwm8_core #(.EXP_MAX(EXP_MAX)) u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ptick_i    (ptick),
      .want_i     (want),
      .duty_i     (cfg.duty),
      .expo_i     (cfg.expo),
      .expo_act_o (expo_act),
      .run_o      (run),
      .active_o   (active)
   );

   // polarity is applied after the comparator, so it acts at once
   assign pwm_o = cfg.pol ? active : !active;

   // R5, R8: a stopped channel drives the inactive level of the current polarity
   p_idle_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |-> (pwm_o == !cfg.pol));
endmodule

// File: tb/tb_pwm8_prescaled.sv
`timescale 1ns/1ps
module tb_pwm8_prescaled;
   localparam int DW = 16;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slow_tick = 1'b0;
   logic          sys_tick = 1'b1;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          pwm;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwm8_prescaled dut (
      .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow_tick), .sys_tick_i(sys_tick),
      .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .pwm_o(pwm)
   );

   // slow tick: one pulse every 4 cycles
   initial begin
      forever begin
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            slow_tick = (k == 3);
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr_reg(input int a, input int d);
      @(negedge clk);
      addr = AW'(a); wdata = DW'(d); wr = 1'b1;
      @(posedge clk); #1;
      wr = 1'b0;
   endtask

   task automatic rd_reg(input int a, output int d);
      @(negedge clk);
      addr = AW'(a); #0.5;
      d = int'(rdata);
   endtask

   task automatic wait_cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic count_high(input int n, output int hi);
      hi = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm) hi++;
      end
   endtask

   task automatic wait_rise(input int limit);
      logic prev;
      @(negedge clk); prev = pwm;
      for (int k = 0; k < limit; k++) begin
         @(negedge clk);
         if (pwm && !prev) return;
         prev = pwm;
      end
   endtask

   task automatic rise_gap(input int limit, output int gap);
      logic prev;
      wait_rise(limit);
      prev = 1'b1; gap = 0;
      for (int k = 0; k < limit; k++) begin
         @(negedge clk);
         gap++;
         if (pwm && !prev) return;
         prev = pwm;
      end
   endtask

   task automatic high_run(input int limit, output int len);
      wait_rise(limit);
      len = 1;
      for (int k = 0; k < limit; k++) begin
         @(negedge clk);
         if (!pwm) return;
         len++;
      end
   endtask

   task automatic t_reset();
      int v;
      rd_reg(4, v); chk("R1", "status after reset", v, 0);
      rd_reg(0, v); chk("R1", "config after reset", v, 0);
      rd_reg(1, v); chk("R1", "source after reset", v, 0);
      chk("R1", "output after reset", int'(pwm), 1);
   endtask

   task automatic t_fields();
      int v;
      wr_reg(0, 'hAB15);
      rd_reg(0, v); chk("R2", "config readback", v, 'hAB15);
      chk("R5", "idle level normal polarity", int'(pwm), 0);
      wr_reg(0, 'hFFFF);
      rd_reg(0, v); chk("R2", "unused bits read zero", v, 'hFF17);
      wr_reg(0, 'hAB05);
      @(negedge clk);
      chk("R5", "idle level inverted polarity", int'(pwm), 1);
   endtask

   task automatic t_enable();
      int v, lat;
      wr_reg(1, 1);
      rd_reg(1, v); chk("R6", "source readback", v, 1);
      wr_reg(0, 'h4013);
      wr_reg(2, 0);
      wait_cycles(20);
      rd_reg(4, v); chk("R7", "zero start write ignored", v, 0);
      wr_reg(2, 1);
      rd_reg(4, v); chk("R7", "status not set in write cycle", v, 0);
      lat = 1;
      while (v == 0 && lat < 20) begin
         rd_reg(4, v);
         lat++;
      end
      chk("R7", "start latency within one prescaled tick", int'(lat >= 1 && lat <= 9), 1);
      chk("R10", "status reads running", v, 1);
   endtask

   task automatic t_duty();
      int hi, g;
      wr_reg(0, 'h4010);
      wait_cycles(4200);
      count_high(256, hi); chk("R3", "high cycles duty 64", hi, 64);
      rise_gap(2000, g);   chk("R3", "period at exponent 0", g, 256);
      wr_reg(0, 'h0010);
      wait_cycles(600);
      count_high(256, hi); chk("R3", "duty 0 stays low", hi, 0);
      wr_reg(0, 'hFF10);
      wait_cycles(600);
      count_high(256, hi); chk("R3", "high cycles duty 255", hi, 255);
   endtask

   task automatic t_shadow();
      int len;
      wr_reg(0, 'h4010);
      wait_cycles(600);
      wait_rise(2000);
      wait_cycles(100);
      wr_reg(0, 'hC810);
      @(negedge clk);
      chk("R9", "duty change waits for wrap", int'(pwm), 0);
      high_run(2000, len);
      chk("R9", "new duty after wrap", len, 200);
   endtask

   task automatic t_pol();
      int hi;
      wr_reg(0, 'h4000);
      count_high(256, hi);
      chk("R5", "inverted polarity high cycles", hi, 192);
   endtask

   task automatic t_src();
      int g, len;
      wr_reg(0, 'h4010);
      wait_cycles(600);
      wr_reg(1, 0);
      rise_gap(5000, g);   chk("R6", "slow tick period", g, 1024);
      high_run(5000, len); chk("R6", "slow tick high time", len, 256);
      wr_reg(1, 1);
      wait_cycles(1100);
   endtask

   task automatic t_presc();
      int g, len;
      wr_reg(0, 'h4012);
      wait_cycles(1100);
      rise_gap(5000, g);   chk("R4", "period at exponent 2", g, 1024);
      high_run(5000, len); chk("R4", "high time at exponent 2", len, 256);
      wr_reg(0, 'h8017);
      wait_cycles(1100);
      rise_gap(40000, g);  chk("R4", "exponent 7 period as 6", g, 16384);
      high_run(40000, len); chk("R4", "exponent 7 high time as 6", len, 8192);
   endtask

   task automatic t_disable();
      int v, lat, hi;
      wr_reg(3, 0);
      wait_cycles(100);
      rd_reg(4, v); chk("R8", "zero stop write ignored", v, 1);
      wr_reg(3, 1);
      rd_reg(4, v); chk("R10", "status still running after stop write", v, 1);
      lat = 1;
      while (v == 1 && lat < 100) begin
         rd_reg(4, v);
         lat++;
      end
      chk("R8", "stop within one prescaled tick", int'(lat <= 65), 1);
      chk("R10", "status reads stopped", v, 0);
      count_high(300, hi); chk("R8", "idle output low for normal polarity", hi, 0);
      wr_reg(0, 'h8007);
      @(negedge clk);
      chk("R5", "idle level follows polarity at once", int'(pwm), 1);
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fields();
      t_enable();
      t_duty();
      t_shadow();
      t_pol();
      t_src();
      t_presc();
      t_disable();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule